// File: doc/BRIEF.md
# One-Wire Byte Transceiver

This block adds byte-wide transfers on top of a one-wire slot engine. Software writes a byte into a shared transmit/receive data port; the byte waits in a transmit buffer until the shifter is free. The shifter then runs eight slots on its own, offering the least significant bit first. For each slot it captures the bit the engine sampled from the line. Because the line is wired-AND, a slot that writes a one is also a read slot, so writing 0xFF reads a whole byte from a device.

When the eighth slot completes, the assembled byte sits in the receive shift register. It moves into the receive buffer only when that buffer is free, so software never sees a partial byte. Four status flags describe the two transmit stages and the two receive stages. An enable register masks these flags onto a single interrupt line. The slot engine is represented by a request/done handshake, with the bit to drive offered alongside the request and the sampled line value returned with the done pulse.

Top module: `onewire_byte_xcvr`

## Requirements
- R1: After reset, status reads 0x0C (transmit buffer empty in bit 2, transmit shifter empty in bit 3, bits 4 and 5 clear), irq is 0, slot_req is 0 and rd_data is 0.
- R2: A write while status bit 2 is set stores the byte and clears both status bits 2 and 3 on the next cycle. A write while bit 2 is clear is dropped, and that byte is never sent.
- R3: A buffered byte enters the shifter when no byte is shifting and status bit 5 is clear, and status bit 2 then sets again. The shifter issues eight slots LSB first. slot_req stays high and slot_bit stays stable until each slot_done.
- R4: On every slot_done, slot_sample is captured LSB first. After a write of 0xFF, the byte that reaches rd_data equals the eight sampled line values.
- R5: Status bit 3 sets on the edge that accepts the eighth slot_done. If a write is accepted on that same edge, bit 3 stays clear.
- R6: Status bit 5 sets when the eighth slot completes. While it is set, no new byte starts and slot_req stays low.
- R7: The completed byte moves to rd_data only while status bit 4 is clear. The move sets bit 4 and clears bit 5. rd_data changes at no other time.
- R8: A pulse on rd_en clears status bit 4. If a received byte moves into the buffer on the same edge, bit 4 stays set.
- R9: Status bits 0, 1, 6 and 7 read 0. ien_we stores bits 2 to 5 of ien_data as the interrupt mask. irq is the OR of status bits 2 to 5, each ANDed with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the transmit/receive data port |
| wr_data | input | BW | Byte to transmit (0xFF to read) |
| rd_en | input | 1 | Read strobe; acknowledges the receive buffer |
| rd_data | output | BW | Receive buffer contents |
| ien_we | input | 1 | Write strobe for the interrupt mask |
| ien_data | input | 8 | Interrupt mask value, bits 2 to 5 used |
| status | output | 8 | Flags: bit 2 tx buffer empty, bit 3 tx shifter empty, bit 4 rx buffer full, bit 5 rx shifter full |
| irq | output | 1 | Masked interrupt request |
| slot_req | output | 1 | Request for one slot from the slot engine |
| slot_bit | output | 1 | Bit to drive in the requested slot |
| slot_done | input | 1 | One-cycle pulse: the slot has finished |
| slot_sample | input | 1 | Line value sampled in the finished slot, valid with slot_done |

## Verification
Two pairs of events can land on the same clock edge. A write accepted on the edge that takes the eighth slot_done must leave the transmit-shifter-empty flag clear. A read strobe given on the edge where a finished byte drops into an empty receive buffer must leave the receive-full flag set. The bench forces both cases from its slot-engine model: it raises wr_en together with the eighth done pulse, and it raises rd_en on the cycle after that pulse. It then judges the flags against a cycle-by-cycle reference model. Heavy random traffic without reads also pushes the receive path into its stall, where the next byte waits behind a full buffer.

// File: rtl/onewire_byte_xcvr.sv
module onewire_byte_xcvr #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_data,
  input  logic          rd_en,
  output logic [BW-1:0] rd_data,
  input  logic          ien_we,
  input  logic [7:0]    ien_data,
  output logic [7:0]    status,
  output logic          irq,
  output logic          slot_req,
  output logic          slot_bit,
  input  logic          slot_done,
  input  logic          slot_sample
);
  localparam int CW = (BW > 1) ? $clog2(BW) : 1;

  logic [BW-1:0] tx_buf, tx_sh, rx_sh, rx_buf;
  logic          tbe, tsre, rbf, rsrf, busy;
  logic [CW-1:0] cnt;
  logic [3:0]    ien;

  wire accept = wr_en & tbe;
  wire load   = ~tbe & ~busy & ~rsrf;
  wire step   = busy & slot_done;
  wire last   = step & (cnt == CW'(BW-1));
  wire xfer   = rsrf & ~rbf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_buf <= '0;
      tbe    <= 1'b1;
      tsre   <= 1'b1;
      rbf    <= 1'b0;
      rsrf   <= 1'b0;
      busy   <= 1'b0;
      cnt    <= '0;
      ien    <= '0;
    end else begin
      if (accept) begin
        tx_buf <= wr_data;
        tbe    <= 1'b0;
      end else if (load) begin
        tbe    <= 1'b1;
      end

      if (load) begin
        tx_sh <= tx_buf;
        busy  <= 1'b1;
        cnt   <= '0;
      end else if (step) begin
        tx_sh <= tx_sh >> 1;
        rx_sh <= {slot_sample, rx_sh[BW-1:1]};
        cnt   <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end

      if (accept)    tsre <= 1'b0;
      else if (last) tsre <= 1'b1;

      if (last)      rsrf <= 1'b1;
      else if (xfer) rsrf <= 1'b0;

      if (xfer) begin
        rx_buf <= rx_sh;
        rbf    <= 1'b1;
      end else if (rd_en) begin
        rbf    <= 1'b0;
      end

      if (ien_we) ien <= ien_data[5:2];
    end
  end

  assign status   = {2'b00, rsrf, rbf, tsre, tbe, 2'b00};
  assign irq      = |(status[5:2] & ien);
  assign rd_data  = rx_buf;
  assign slot_req = busy;
  assign slot_bit = tx_sh[0];

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_done |=> slot_req);                                 // R3
  AST_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_done |=> $stable(slot_bit));                        // R3
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && status[2] |=> !status[2] && !status[3]);                     // R2
  AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> !slot_req);                                             // R6
  AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(status[5]) && !$past(status[4]));         // R7
endmodule

// File: tb/tb_onewire_byte_xcvr.sv
module tb_onewire_byte_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, ien_we = 0, slot_done = 0, slot_sample = 0;
  logic [7:0] wr_data = 0, ien_data = 0, rd_data, status;
  logic irq, slot_req, slot_bit;

  onewire_byte_xcvr #(.BW(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .ien_we(ien_we), .ien_data(ien_data), .status(status),
    .irq(irq), .slot_req(slot_req), .slot_bit(slot_bit),
    .slot_done(slot_done), .slot_sample(slot_sample));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int m_tbe = 1, m_tsre = 1, m_rbf = 0, m_rsrf = 0, m_busy = 0, m_cnt = 0;
  int m_buf = 0, m_tx = 0, m_rx = 0, m_rxbuf = 0, m_ien = 0;
  int eng_cnt = 0, lat = 2, dbit = 0;
  logic [7:0] dev_byte = 8'hFF;
  bit hit_wr = 0, hit_rd = 0, rd_arm = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic model_edge();
    int o_tbe, o_busy, o_rsrf, o_rbf;
    bit acc, xfer;
    o_tbe = m_tbe; o_busy = m_busy; o_rsrf = m_rsrf; o_rbf = m_rbf;
    acc  = wr_en && o_tbe != 0;
    xfer = o_rsrf != 0 && o_rbf == 0;
    if (acc) begin m_buf = wr_data; m_tbe = 0; m_tsre = 0; end
    if (!o_tbe && !o_busy && !o_rsrf) begin
      m_tx = m_buf; m_busy = 1; m_cnt = 0; m_tbe = 1;
    end
    if (o_busy && slot_done) begin
      m_rx = (m_rx >> 1) | (int'(slot_sample) << 7);
      m_tx = m_tx >> 1;
      m_cnt++;
      if (m_cnt == 8) begin
        m_busy = 0; m_rsrf = 1;
        if (!acc) m_tsre = 1;
      end
    end
    if (xfer) begin m_rxbuf = m_rx; m_rbf = 1; m_rsrf = 0; end
    else if (rd_en) m_rbf = 0;
    if (ien_we) m_ien = ien_data & 8'h3C;
  endtask

  task automatic compare();
    int st;
    st = (m_rsrf << 5) | (m_rbf << 4) | (m_tsre << 3) | (m_tbe << 2);
    chk("R3 slot_req", slot_req, m_busy);
    if (m_busy) chk("R3 slot_bit", slot_bit, m_tx & 1);
    chk("R2 tx buffer empty", status[2], m_tbe);
    chk("R5 tx shifter empty", status[3], m_tsre);
    chk("R8 rx buffer full", status[4], m_rbf);
    chk("R6 rx shifter full", status[5], m_rsrf);
    chk("R9 unused status bits", {status[7:6], status[1:0]}, 0);
    chk("R7 rd_data", rd_data, m_rxbuf);
    chk("R9 irq", irq, (st & m_ien) != 0);
  endtask

  task automatic engine();
    if (rd_arm) begin rd_arm = 0; if (hit_rd) rd_en = 1; end
    if (slot_done) begin
      slot_done = 0; eng_cnt = 0;
    end else if (slot_req) begin
      eng_cnt++;
      if (eng_cnt >= lat) begin
        slot_done = 1;
        slot_sample = slot_bit & dev_byte[dbit];
        dbit = (dbit + 1) % 8;
        if (m_cnt == 7) begin
          rd_arm = 1;
          if (hit_wr) begin wr_en = 1; wr_data = 8'h5A; end
        end
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    compare();
    wr_en = 0; rd_en = 0; ien_we = 0;
    engine();
  endtask

  task automatic settle();
    for (int i = 0; i < 600; i++) begin
      if (!m_busy && m_tbe && !m_rsrf && !slot_done) break;
      step();
    end
  endtask

  task automatic send(input logic [7:0] b);
    wr_en = 1; wr_data = b; step();
  endtask

  task automatic do_read();
    rd_en = 1; step();
  endtask

  initial begin
    #(10 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 8'h0C);
    chk("R1 irq", irq, 0);
    chk("R1 slot_req", slot_req, 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    step();
    ien_we = 1; ien_data = 8'hFF; step();

    dev_byte = 8'hFF; dbit = 0; send(8'hA5); settle();
    chk("R4 write byte echoed", rd_data, 8'hA5);
    do_read();
    chk("R8 read clears full", status[4], 0);

    dev_byte = 8'h3C; dbit = 0; send(8'hFF); settle();
    chk("R4 read byte from line", rd_data, 8'h3C);
    do_read();

    dev_byte = 8'hFF; dbit = 0;
    send(8'h11); send(8'h22);
    step(); step(); send(8'h33);
    for (int i = 0; i < 80; i++) step();
    chk("R6 stalled behind full buffer", status[5], 1);
    chk("R6 no slot while stalled", slot_req, 0);
    chk("R2 dropped write not seen", rd_data, 8'h11);
    do_read(); settle();
    chk("R7 second byte delivered", rd_data, 8'h33);
    do_read();

    ien_we = 1; ien_data = 8'h10; step();
    chk("R9 masked irq idle", irq, 0);
    hit_wr = 1; send(8'h81); settle(); hit_wr = 0;
    chk("R9 irq on rx full", irq, 1);
    do_read(); settle();
    do_read();

    hit_rd = 1; send(8'h7E); settle(); hit_rd = 0;
    chk("R8 transfer wins over read", status[4], 1);
    do_read();

    ien_we = 1; ien_data = 8'h3C; step();
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) begin wr_en = 1; wr_data = 8'($urandom); end
      if ($urandom_range(0, 7) == 0) rd_en = 1;
      if ($urandom_range(0, 200) == 0) begin ien_we = 1; ien_data = 8'($urandom); end
      lat = $urandom_range(1, 4);
      dev_byte = 8'($urandom);
      hit_wr = ($urandom_range(0, 3) == 0);
      hit_rd = ($urandom_range(0, 3) == 0);
      step();
    end
    summary();
  end
endmodule